// File: doc/BRIEF.md
# Store Buffer Ownership Request Scheduler

The block sits beside an in-order buffer of retired stores and decides when to ask for write ownership of the cache lines those stores will write. Each ownership request claims one miss slot from a small fill-buffer pool. When the oldest store misses in L1 and has no request in flight, the block always sends a demand request for it. For a few younger stores it can also send requests ahead of time. It uses the exact line addresses held in the buffer and does no address prediction.

Early requests are held back in two cases: when too few fill buffers are free, and when a saturating throttle has seen too many prefetched lines stolen by other agents before their store wrote. Stores to a line that already has a request in flight share that request. When a fill completes, every waiting store to that line becomes owned. The oldest store then commits on the following cycle and frees its buffer entry.

Top module: `rfo_prefetch_sched`

## Requirements
- R1: When the buffer is not empty, the oldest entry is neither owned nor tracked, no busy fill buffer holds its line, and at least one fill buffer is free, the block issues a request for that entry in the same cycle with `rfo_early_o`=0.
- R2: Early requests (`rfo_early_o`=1) go only to entries at age positions 1 to LOOKAHEAD-1 behind the oldest. The oldest qualifying entry is chosen, at most one request is issued per cycle, and no early request is issued in a cycle in which the oldest entry needs a request.
- R3: An early request is issued only when the number of free fill buffers is at least EARLY_THR.
- R4: An entry that is tracked (request sent) or owned receives no further request until a snoop takes its ownership away.
- R5: An entry whose line equals the line of a busy fill buffer is attached to that buffer and gets no request of its own.
- R6: A request always takes the lowest-numbered free fill buffer, reported on `rfo_fb_o`. `fill_valid_i` with index `fill_fb_i` frees that buffer and marks owned every valid entry whose line matches the buffer's line.
- R7: When the oldest entry is owned, `commit_o` is high in that cycle with its line on `commit_line_o`, and the entry leaves the buffer at the next edge. This is one commit per cycle in age order. A store enqueued with `enq_hit_i`=1 is owned from the start and needs no request.
- R8: `snoop_valid_i` clears ownership of every owned entry whose line equals `snoop_line_i`, so that entry is requested again. A snoop that matches the oldest entry suppresses its commit in that cycle.
- R9: A 3-bit saturating counter rises by one when a snoop strips an entry whose request was early, and falls by one when a store that missed in L1 commits. While it is 4 or above, no early request is issued.
- R10: `sb_full_o` is high when SB_DEPTH entries are held, and an enqueue while full is dropped.
- R11: After reset the buffer is empty, all fill buffers are free, the throttle is zero, and `rfo_valid_o`, `commit_o` and `sb_full_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | Retired store enters the buffer |
| enq_line_i | input | LINE_W | Line address of the entering store |
| enq_hit_i | input | 1 | L1 lookup hit with write permission for the entering store |
| sb_full_o | output | 1 | Buffer holds SB_DEPTH entries |
| fill_valid_i | input | 1 | Fill completed for a fill buffer |
| fill_fb_i | input | clog2(FB_NUM) | Index of the completed fill buffer |
| snoop_valid_i | input | 1 | Another agent took a line away |
| snoop_line_i | input | LINE_W | Line address lost |
| rfo_valid_o | output | 1 | Ownership request issued this cycle |
| rfo_early_o | output | 1 | Request is ahead of the oldest store |
| rfo_fb_o | output | clog2(FB_NUM) | Fill buffer claimed by the request |
| rfo_line_o | output | LINE_W | Line address requested |
| commit_o | output | 1 | Oldest store writes and leaves |
| commit_line_o | output | LINE_W | Line written by the committing store |

## Verification
A lost tracking bit shows up within one cycle as a duplicate request on the same line. A stuck tracking bit shows up as an oldest store that never gets a request, so its commit never comes. A wrong owned bit either lets a store commit before its fill or leaves it stuck after a fill. A free-buffer count that drifts shows as an early request issued below the threshold, or as a wrong `rfo_fb_o` index on the next request. Throttle errors appear only after several stolen lines, as early requests that either continue when they should stop or stop too early. For that reason the bench replays the steal sequence exactly four times.

// File: rtl/rfo_sched_pkg.sv
package rfo_sched_pkg;
  localparam int unsigned THR_W   = 3;
  localparam int unsigned THR_CUT = 4;
  localparam logic [THR_W-1:0] THR_MAX = '1;
endpackage

// File: rtl/rfo_prio_enc.sv
module rfo_prio_enc #(
  parameter int unsigned W  = 4,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/rfo_fb_pool.sv
module rfo_fb_pool #(
  parameter int unsigned FB_NUM = 10,
  parameter int unsigned LINE_W = 26,
  localparam int unsigned FB_W  = $clog2(FB_NUM),
  localparam int unsigned FBC_W = $clog2(FB_NUM + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_i,
  input  logic [LINE_W-1:0]              alloc_line_i,
  input  logic                           rel_i,
  input  logic [FB_W-1:0]                rel_idx_i,
  output logic [FB_NUM-1:0]              busy_o,
  output logic [FB_NUM-1:0][LINE_W-1:0]  line_o,
  output logic [FB_W-1:0]                free_idx_o,
  output logic [FBC_W-1:0]               free_cnt_o
);
  logic [FB_NUM-1:0]             busy_q;
  logic [FB_NUM-1:0][LINE_W-1:0] line_q;
  logic                          any_free;

  rfo_prio_enc #(.W(FB_NUM), .IW(FB_W)) u_free_pick (
    .req_i (~busy_q),
    .any_o (any_free),
    .idx_o (free_idx_o)
  );

  always_comb begin
    free_cnt_o = '0;
    for (int f = 0; f < FB_NUM; f++) begin
      if (!busy_q[f]) free_cnt_o = free_cnt_o + FBC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      line_q <= '0;
    end else begin
      for (int f = 0; f < FB_NUM; f++) begin
        if (rel_i && rel_idx_i == FB_W'(f)) busy_q[f] <= 1'b0;
        if (alloc_i && any_free && free_idx_o == FB_W'(f)) begin
          busy_q[f] <= 1'b1;
          line_q[f] <= alloc_line_i;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = line_q;
endmodule

// File: rtl/rfo_throttle.sv
module rfo_throttle
  import rfo_sched_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             waste_i,
  input  logic             useful_i,
  output logic [THR_W-1:0] lvl_o,
  output logic             cut_o
);
  logic [THR_W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else if (waste_i && !useful_i) begin
      if (lvl_q != THR_MAX) lvl_q <= lvl_q + 1'b1;
    end else if (useful_i && !waste_i) begin
      if (lvl_q != '0) lvl_q <= lvl_q - 1'b1;
    end
  end

  assign lvl_o = lvl_q;
  assign cut_o = lvl_q >= THR_W'(THR_CUT);
endmodule

// File: rtl/rfo_prefetch_sched.sv
module rfo_prefetch_sched
  import rfo_sched_pkg::*;
#(
  parameter int unsigned SB_DEPTH  = 42,
  parameter int unsigned FB_NUM    = 10,
  parameter int unsigned LOOKAHEAD = 4,
  parameter int unsigned EARLY_THR = 3,
  parameter int unsigned LINE_W    = 26
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enq_valid_i,
  input  logic [LINE_W-1:0]          enq_line_i,
  input  logic                       enq_hit_i,
  output logic                       sb_full_o,
  input  logic                       fill_valid_i,
  input  logic [$clog2(FB_NUM)-1:0]  fill_fb_i,
  input  logic                       snoop_valid_i,
  input  logic [LINE_W-1:0]          snoop_line_i,
  output logic                       rfo_valid_o,
  output logic                       rfo_early_o,
  output logic [$clog2(FB_NUM)-1:0]  rfo_fb_o,
  output logic [LINE_W-1:0]          rfo_line_o,
  output logic                       commit_o,
  output logic [LINE_W-1:0]          commit_line_o
);
  localparam int unsigned SLOT_W = $clog2(SB_DEPTH);
  localparam int unsigned CNT_W  = $clog2(SB_DEPTH + 1);
  localparam int unsigned FB_W   = $clog2(FB_NUM);
  localparam int unsigned FBC_W  = $clog2(FB_NUM + 1);
  localparam int unsigned LA_W   = (LOOKAHEAD > 1) ? $clog2(LOOKAHEAD) : 1;

  // per-entry state
  logic [SB_DEPTH-1:0]             vld_q, miss_q, own_q, trk_q, early_q;
  logic [SB_DEPTH-1:0][LINE_W-1:0] line_q;
  logic [SB_DEPTH-1:0][FB_W-1:0]   tfb_q;
  logic [SLOT_W-1:0]               head_q, tail_q;
  logic [CNT_W-1:0]                cnt_q;

  // pool and throttle
  logic [FB_NUM-1:0]             fb_busy;
  logic [FB_NUM-1:0][LINE_W-1:0] fb_line;
  logic [FB_W-1:0]               free_idx;
  logic [FBC_W-1:0]              free_cnt;
  logic [THR_W-1:0]              thr_lvl;
  logic                          thr_cut;

  logic [SB_DEPTH-1:0]           cov_hit, need, snp, fill_own;
  logic [SB_DEPTH-1:0][FB_W-1:0] cov_fb;
  logic [LOOKAHEAD-1:0][SLOT_W-1:0] pos_slot;
  logic [LOOKAHEAD-1:0]          ecand;
  logic                          e_any;
  logic [LA_W-1:0]               e_idx;
  logic [SLOT_W-1:0]             e_slot, iss_slot;
  logic                          head_need, demand, early_go, issue;
  logic                          enq_acc, waste, useful, empty;
  int                            win_n;

  function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(SB_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  rfo_fb_pool #(.FB_NUM(FB_NUM), .LINE_W(LINE_W)) u_pool (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (issue),
    .alloc_line_i (rfo_line_o),
    .rel_i        (fill_valid_i),
    .rel_idx_i    (fill_fb_i),
    .busy_o       (fb_busy),
    .line_o       (fb_line),
    .free_idx_o   (free_idx),
    .free_cnt_o   (free_cnt)
  );

  rfo_throttle u_thr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .waste_i  (waste),
    .useful_i (useful),
    .lvl_o    (thr_lvl),
    .cut_o    (thr_cut)
  );

  // line match against pool, snoop and fill
  always_comb begin
    for (int s = 0; s < SB_DEPTH; s++) begin
      cov_hit[s] = 1'b0;
      cov_fb[s]  = '0;
      for (int f = 0; f < FB_NUM; f++) begin
        if (fb_busy[f] && fb_line[f] == line_q[s]) begin
          cov_hit[s] = 1'b1;
          cov_fb[s]  = FB_W'(f);
        end
      end
      need[s]     = vld_q[s] && !own_q[s] && !trk_q[s] && !cov_hit[s];
      snp[s]      = snoop_valid_i && vld_q[s] && own_q[s] && line_q[s] == snoop_line_i;
      fill_own[s] = fill_valid_i && vld_q[s] && fb_busy[fill_fb_i]
                    && line_q[s] == fb_line[fill_fb_i];
    end
  end

  // lookahead window in age order
  assign win_n = thr_cut ? 1 : int'(LOOKAHEAD);

  always_comb begin
    for (int k = 0; k < LOOKAHEAD; k++) begin
      logic [SLOT_W:0] sum;
      sum = {1'b0, head_q} + (SLOT_W + 1)'(k);
      if (sum >= (SLOT_W + 1)'(SB_DEPTH)) sum = sum - (SLOT_W + 1)'(SB_DEPTH);
      pos_slot[k] = sum[SLOT_W-1:0];
      ecand[k]    = (k != 0) && (k < win_n) && (k < int'(cnt_q)) && need[pos_slot[k]];
    end
  end

  rfo_prio_enc #(.W(LOOKAHEAD), .IW(LA_W)) u_early_pick (
    .req_i (ecand),
    .any_o (e_any),
    .idx_o (e_idx)
  );

  assign e_slot    = pos_slot[e_idx];
  assign empty     = (cnt_q == '0);
  assign head_need = !empty && need[head_q];
  assign demand    = head_need && (free_cnt != '0);
  assign early_go  = !head_need && e_any && (int'(free_cnt) >= int'(EARLY_THR));
  assign issue     = demand || early_go;
  assign iss_slot  = demand ? head_q : e_slot;

  assign rfo_valid_o   = issue;
  assign rfo_early_o   = early_go;
  assign rfo_fb_o      = free_idx;
  assign rfo_line_o    = line_q[iss_slot];
  assign commit_o      = !empty && own_q[head_q] && !snp[head_q];
  assign commit_line_o = line_q[head_q];
  assign sb_full_o     = (cnt_q == CNT_W'(SB_DEPTH));
  assign enq_acc       = enq_valid_i && !sb_full_o;
  assign waste         = |(snp & early_q);
  assign useful        = commit_o && miss_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      miss_q  <= '0;
      own_q   <= '0;
      trk_q   <= '0;
      early_q <= '0;
      line_q  <= '0;
      tfb_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      for (int s = 0; s < SB_DEPTH; s++) begin
        if (enq_acc && tail_q == SLOT_W'(s)) begin
          vld_q[s]   <= 1'b1;
          line_q[s]  <= enq_line_i;
          miss_q[s]  <= !enq_hit_i;
          own_q[s]   <= enq_hit_i;
          trk_q[s]   <= 1'b0;
          early_q[s] <= 1'b0;
        end else begin
          if (commit_o && head_q == SLOT_W'(s)) vld_q[s] <= 1'b0;
          if (vld_q[s] && !own_q[s] && !trk_q[s] && cov_hit[s]) begin
            trk_q[s] <= 1'b1;
            tfb_q[s] <= cov_fb[s];
          end
          if (issue && iss_slot == SLOT_W'(s)) begin
            trk_q[s]   <= 1'b1;
            tfb_q[s]   <= free_idx;
            early_q[s] <= early_go;
          end
          if (snp[s]) begin
            own_q[s]   <= 1'b0;
            early_q[s] <= 1'b0;
          end
          if (fill_own[s]) begin
            own_q[s] <= 1'b1;
            trk_q[s] <= 1'b0;
          end
        end
      end
      if (enq_acc)  tail_q <= nxt(tail_q);
      if (commit_o) head_q <= nxt(head_q);
      cnt_q <= cnt_q + CNT_W'(enq_acc) - CNT_W'(commit_o);
    end
  end
endmodule

module rfo_prefetch_sched_chk #(
  parameter int unsigned SB_DEPTH  = 42,
  parameter int unsigned FB_NUM    = 10,
  parameter int unsigned EARLY_THR = 3,
  localparam int unsigned CNT_W = $clog2(SB_DEPTH + 1),
  localparam int unsigned FB_W  = $clog2(FB_NUM),
  localparam int unsigned FBC_W = $clog2(FB_NUM + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rfo_valid_o,
  input logic              rfo_early_o,
  input logic [FB_W-1:0]   rfo_fb_o,
  input logic              commit_o,
  input logic              enq_valid_i,
  input logic              sb_full_o,
  input logic [FB_NUM-1:0] fb_busy,
  input logic [FBC_W-1:0]  free_cnt,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [2:0]        thr_lvl
);
  // R6
  fb_free_on_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfo_valid_o |-> !fb_busy[rfo_fb_o]);
  // R3
  early_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfo_valid_o && rfo_early_o |-> free_cnt >= FBC_W'(EARLY_THR));
  // R9
  throttle_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_lvl >= 3'd4 |-> !(rfo_valid_o && rfo_early_o));
  // R7
  commit_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o && !enq_valid_i |=> cnt_q == $past(cnt_q) - 1'b1);
  // R10
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_full_o && enq_valid_i && !commit_o |=> cnt_q == $past(cnt_q));
  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SB_DEPTH));
endmodule

bind rfo_prefetch_sched rfo_prefetch_sched_chk #(
  .SB_DEPTH(SB_DEPTH), .FB_NUM(FB_NUM), .EARLY_THR(EARLY_THR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rfo_valid_o (rfo_valid_o),
  .rfo_early_o (rfo_early_o),
  .rfo_fb_o    (rfo_fb_o),
  .commit_o    (commit_o),
  .enq_valid_i (enq_valid_i),
  .sb_full_o   (sb_full_o),
  .fb_busy     (fb_busy),
  .free_cnt    (free_cnt),
  .cnt_q       (cnt_q),
  .thr_lvl     (thr_lvl)
);

// File: tb/tb_rfo_prefetch_sched.sv
module tb_rfo_prefetch_sched;
  localparam int unsigned SB_DEPTH  = 8;
  localparam int unsigned FB_NUM    = 4;
  localparam int unsigned LOOKAHEAD = 4;
  localparam int unsigned EARLY_THR = 3;
  localparam int unsigned LINE_W    = 16;
  localparam int unsigned FB_W      = $clog2(FB_NUM);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enq_valid_i = 1'b0, enq_hit_i = 1'b0;
  logic [LINE_W-1:0] enq_line_i = '0;
  logic fill_valid_i = 1'b0;
  logic [FB_W-1:0] fill_fb_i = '0;
  logic snoop_valid_i = 1'b0;
  logic [LINE_W-1:0] snoop_line_i = '0;
  logic sb_full_o, rfo_valid_o, rfo_early_o, commit_o;
  logic [FB_W-1:0] rfo_fb_o;
  logic [LINE_W-1:0] rfo_line_o, commit_line_o;

  int checks = 0, failures = 0;
  logic [LINE_W+FB_W:0] exp_rfo[$];
  logic [LINE_W-1:0]    exp_cmt[$];

  always #2 clk = ~clk;

  rfo_prefetch_sched #(
    .SB_DEPTH(SB_DEPTH), .FB_NUM(FB_NUM), .LOOKAHEAD(LOOKAHEAD),
    .EARLY_THR(EARLY_THR), .LINE_W(LINE_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid_i), .enq_line_i(enq_line_i), .enq_hit_i(enq_hit_i),
    .sb_full_o(sb_full_o),
    .fill_valid_i(fill_valid_i), .fill_fb_i(fill_fb_i),
    .snoop_valid_i(snoop_valid_i), .snoop_line_i(snoop_line_i),
    .rfo_valid_o(rfo_valid_o), .rfo_early_o(rfo_early_o), .rfo_fb_o(rfo_fb_o),
    .rfo_line_o(rfo_line_o), .commit_o(commit_o), .commit_line_o(commit_line_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enq(input logic [LINE_W-1:0] l, input logic hit);
    enq_valid_i = 1'b1; enq_line_i = l; enq_hit_i = hit;
    step();
    enq_valid_i = 1'b0; enq_hit_i = 1'b0;
  endtask

  task automatic fill(input int f);
    fill_valid_i = 1'b1; fill_fb_i = FB_W'(f);
    step();
    fill_valid_i = 1'b0;
  endtask

  task automatic snoop(input logic [LINE_W-1:0] l);
    snoop_valid_i = 1'b1; snoop_line_i = l;
    step();
    snoop_valid_i = 1'b0;
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    chk(rfo_valid_o == 1'b0, req, "no request expected", 32'(rfo_valid_o), 32'd0);
  endtask

  task automatic push_rfo(input logic [LINE_W-1:0] l, input logic e, input int f);
    exp_rfo.push_back({l, e, FB_W'(f)});
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_ni && rfo_valid_o) begin
      if (exp_rfo.size() == 0) begin
        chk(1'b0, "R4", "unexpected request", 32'(rfo_line_o), 32'd0);
      end else begin
        logic [LINE_W+FB_W:0] e;
        e = exp_rfo.pop_front();
        chk({rfo_line_o, rfo_early_o, rfo_fb_o} == e,
            e[FB_W] ? "R2 R6" : "R1 R6", "request {line,early,fb}",
            32'({rfo_line_o, rfo_early_o, rfo_fb_o}), 32'(e));
      end
    end
    if (rst_ni && commit_o) begin
      if (exp_cmt.size() == 0) begin
        chk(1'b0, "R7", "unexpected commit", 32'(commit_line_o), 32'd0);
      end else begin
        logic [LINE_W-1:0] c;
        c = exp_cmt.pop_front();
        chk(commit_line_o == c, "R7", "commit line", 32'(commit_line_o), 32'(c));
      end
    end
  end

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    // R11 reset state
    chk(rfo_valid_o == 1'b0, "R11", "rfo_valid in reset", 32'(rfo_valid_o), 32'd0);
    chk(commit_o == 1'b0, "R11", "commit in reset", 32'(commit_o), 32'd0);
    chk(sb_full_o == 1'b0, "R11", "full in reset", 32'(sb_full_o), 32'd0);
    rst_ni = 1'b1;
    step(2);

    // S1: free-buffer gating, snoop on head, demand with few free
    push_rfo(16'h0100, 1'b0, 0);
    push_rfo(16'h0101, 1'b1, 1);
    push_rfo(16'h0102, 1'b1, 0);
    push_rfo(16'h0100, 1'b0, 2);
    exp_cmt.push_back(16'h0100);
    exp_cmt.push_back(16'h0101);
    exp_cmt.push_back(16'h0102);
    enq(16'h0100, 1'b0);
    enq(16'h0101, 1'b0);
    enq(16'h0102, 1'b0);
    idle_chk("R3");
    step();
    idle_chk("R4");
    step();
    fill(0);
    snoop_valid_i = 1'b1; snoop_line_i = 16'h0100;
    @(negedge clk);
    chk(commit_o == 1'b0, "R8", "commit suppressed by snoop", 32'(commit_o), 32'd0);
    step();
    snoop_valid_i = 1'b0;
    step(3);
    fill(2); step(3);
    fill(1); step(3);
    fill(0); step(3);

    // S2: shared line and L1 hit
    push_rfo(16'h0200, 1'b0, 0);
    exp_cmt.push_back(16'h0200);
    exp_cmt.push_back(16'h0200);
    exp_cmt.push_back(16'h0300);
    enq(16'h0200, 1'b0);
    enq(16'h0200, 1'b0);
    idle_chk("R5");
    enq(16'h0300, 1'b1);
    step(2);
    fill(0);
    step(5);

    // S3: stolen early lines drive the throttle to head-only (R9)
    push_rfo(16'h0400, 1'b0, 0);
    for (int i = 0; i < 4; i++) push_rfo(16'h0401, 1'b1, 1);
    push_rfo(16'h0401, 1'b0, 0);
    exp_cmt.push_back(16'h0400);
    exp_cmt.push_back(16'h0401);
    enq(16'h0400, 1'b0);
    enq(16'h0401, 1'b0);
    step(3);
    for (int i = 0; i < 4; i++) begin
      fill(1);
      step();
      snoop(16'h0401);
      step(2);
    end
    idle_chk("R9");
    step();
    idle_chk("R9");
    step();
    fill(0); step(3);
    fill(0); step(4);

    // S4: full buffer, dropped enqueue, drain with early refill
    for (int i = 0; i < 8; i++) begin
      push_rfo(16'h0500 + 16'(i), (i != 0), i % 2);
      exp_cmt.push_back(16'h0500 + 16'(i));
    end
    for (int i = 0; i < 8; i++) enq(16'h0500 + 16'(i), 1'b0);
    chk(sb_full_o == 1'b1, "R10", "full after depth enqueues", 32'(sb_full_o), 32'd1);
    enq(16'h05FF, 1'b0);
    step();
    for (int i = 0; i < 8; i++) begin
      fill(i % 2);
      step(3);
    end
    chk(sb_full_o == 1'b0, "R10", "not full after drain", 32'(sb_full_o), 32'd0);
    step(3);

    chk(exp_rfo.size() == 0, "R1 R2", "requests outstanding", 32'(exp_rfo.size()), 32'd0);
    chk(exp_cmt.size() == 0, "R7", "commits outstanding", 32'(exp_cmt.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule